// File: doc/BRIEF.md
# Watchdog Timer with Reset Control and Status

This block is a small watchdog timer for one clock domain. An up-counter advances on a single-cycle prescaler tick while its run bit is set. A timer control register selects between two modes. In watchdog mode, a wrap of the counter from all ones to zero is treated as a failure. In interval mode, the same wrap is a periodic event. Software reaches the counter, the control register and an 8-bit reset control/status register over a plain register bus. The bus has a one-cycle write strobe, a read strobe and a combinational read path. It has no back-pressure: every access completes in the cycle its strobe is high.

In watchdog mode, an overflow sets a sticky overflow flag. Depending on the reset-enable bit, the block then does one of two things:
- It requests a chip reset as a one-cycle pulse. A type-select bit chooses between a power-on and a manual reset request.
- It issues no request and returns its own counter and control register to their reset values.

In interval mode, an overflow raises a one-cycle interrupt pulse instead. It leaves the flag untouched, and the reset settings have no effect. The flag can only be cleared by a qualified sequence: a status read that returns the flag as 1, then a status write with bit 7 at 0.

Top module: `wdog_reset_ctrl`

## Requirements
- R1: After reset the counter (address 0) reads 0x00, the control register (address 1) reads 0x00, the status register (address 2) reads 0x1F, and the interrupt and both reset request outputs are low.
- R2: Status register layout: bit 7 is the overflow flag, bit 6 is reset enable and bit 5 is reset type. Bits 6 and 5 store the written value. Bits 4 to 0 always read 1 and ignore writes.
- R3: Control bit 0 is run and bit 1 is mode (1 = watchdog, 0 = interval); the other control bits read 0. The counter occupies the low CNT_W bits of address 0, and its upper bits read 0. It increments by one on each tick while run is 1 and holds while run is 0. A counter write in the same cycle as a tick takes the written value.
- R4: A tick with the counter at all ones and run set wraps the counter to 0. In watchdog mode this sets the overflow flag, which reads 1 from the next cycle on.
- R5: An overflow in interval mode gives a pulse of exactly one cycle on `irq_interval`, starting the cycle after the tick. The flag is left unchanged.
- R6: A watchdog-mode overflow with reset enable 1 gives a pulse of exactly one cycle, starting the cycle after the tick. With reset type 0 the pulse is on `rst_req_por`; with reset type 1 it is on `rst_req_manual`. The counter wraps to 0 and the control register keeps its value.
- R7: A watchdog-mode overflow with reset enable 0 raises no reset request. The counter and the control register both return to 0x00.
- R8: A status write clears the flag only when it writes bit 7 as 0 and comes after a status read that returned the flag as 1. A status write without such a read, or a write of 1 to bit 7, leaves the flag set.
- R9: Any status write withdraws the qualification of an earlier read, so a second write with no new read in between does not clear the flag.
- R10: If an overflow in watchdog mode falls in the same cycle as a qualified clearing write, the flag stays set.
- R11: In interval mode, reset enable and reset type have no effect. No reset request is raised, and the counter and control register are not reinitialised on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle prescaler tick |
| bus_addr | input | 2 | Register address: 0 counter, 1 control, 2 status |
| bus_rd | input | 1 | Read strobe (qualifies the flag-clear sequence) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq_interval | output | 1 | One-cycle interval interrupt pulse |
| rst_req_por | output | 1 | One-cycle power-on reset request |
| rst_req_manual | output | 1 | One-cycle manual reset request |

## Verification
Register writes and ticks act at the next rising edge. Read data is combinational, so it is sampled within the same cycle, before that edge. The bench therefore drives inputs at the falling edge and reads data 1 ns later. It checks pulse outputs at the falling edge right after the tick's edge, where they are due. It checks them once more one cycle later to confirm each pulse lasts exactly one cycle. The counter sweep runs a 4-bit counter from preloads of 0, 7 and 15 under all eight combinations of mode, reset enable and reset type, and computes the number of ticks to overflow as 16 minus the preload. A flag read issued after a write always lands a full cycle later, so the write's effect is settled when the flag is observed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_CNT  = 2'd0,
    ADDR_CTL  = 2'd1,
    ADDR_STAT = 2'd2
  } reg_addr_e;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_MODE_BIT = 1;

  localparam int STAT_FLAG_BIT  = 7;
  localparam int STAT_RSTEN_BIT = 6;
  localparam int STAT_RTYPE_BIT = 5;
  localparam logic [4:0] STAT_RSVD = 5'h1F;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             self_clear,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run,
  output logic             wd_mode,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign ovf = run & tick & ~cnt_we & (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run     <= 1'b0;
      wd_mode <= 1'b0;
    end else if (self_clear) begin
      cnt_q   <= '0;
      run     <= 1'b0;
      wd_mode <= 1'b0;
    end else begin
      if (cnt_we)
        cnt_q <= wdata[CNT_W-1:0];
      else if (run && tick)
        cnt_q <= cnt_q + 1'b1;
      if (ctl_we) begin
        run     <= wdata[CTL_RUN_BIT];
        wd_mode <= wdata[CTL_MODE_BIT];
      end
    end
  end

  // R3: a stopped counter with no write keeps its value
  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> (cnt_q == $past(cnt_q)));

  // R4: an overflow wraps the counter to zero
  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == '0));

  // R7: self clear returns counter and control to reset values
  assert_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    self_clear |=> (cnt_q == '0 && !run && !wd_mode));
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stat,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  input  logic             wd_ovf,
  output logic             flag,
  output logic             rst_en,
  output logic             rst_type
);
  logic armed;
  logic clr_req;

  assign clr_req = wr_stat & armed & ~wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      flag     <= 1'b0;
      rst_en   <= 1'b0;
      rst_type <= 1'b0;
    end else begin
      if (wr_stat)
        armed <= 1'b0;
      else if (rd_stat && flag)
        armed <= 1'b1;

      if (wd_ovf)
        flag <= 1'b1;
      else if (clr_req)
        flag <= 1'b0;

      if (wr_stat) begin
        rst_en   <= wdata[STAT_RSTEN_BIT];
        rst_type <= wdata[STAT_RTYPE_BIT];
      end
    end
  end

  // R4: a watchdog overflow sets the flag
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ovf |=> flag);

  // R8: without a qualified write the flag stays set
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_stat && armed)) |=> flag);

  // R9: a write with no fresh qualifying read never clears
  assert_no_clear_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_stat && !armed) |=> flag);

  // R8: the flag only falls after a qualified clearing write
  assert_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_stat && armed && !wdata[STAT_FLAG_BIT]));
endmodule

// File: rtl/wdog_reset_ctrl.sv
module wdog_reset_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq_interval,
  output logic             rst_req_por,
  output logic             rst_req_manual
);
  logic [CNT_W-1:0] cnt_q;
  logic run, wd_mode, ovf;
  logic flag, rst_en, rst_type;
  logic wd_ovf, itv_ovf, self_clear;
  logic sel_cnt, sel_ctl, sel_stat;

  assign sel_cnt  = (bus_addr == ADDR_CNT);
  assign sel_ctl  = (bus_addr == ADDR_CTL);
  assign sel_stat = (bus_addr == ADDR_STAT);

  assign wd_ovf     = ovf & wd_mode;
  assign itv_ovf    = ovf & ~wd_mode;
  assign self_clear = wd_ovf & ~rst_en;

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cnt_we     (bus_wr & sel_cnt),
    .ctl_we     (bus_wr & sel_ctl),
    .wdata      (bus_wdata),
    .self_clear (self_clear),
    .cnt_q      (cnt_q),
    .run        (run),
    .wd_mode    (wd_mode),
    .ovf        (ovf)
  );

  wdog_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stat  (bus_rd & sel_stat),
    .wr_stat  (bus_wr & sel_stat),
    .wdata    (bus_wdata),
    .wd_ovf   (wd_ovf),
    .flag     (flag),
    .rst_en   (rst_en),
    .rst_type (rst_type)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_interval   <= 1'b0;
      rst_req_por    <= 1'b0;
      rst_req_manual <= 1'b0;
    end else begin
      irq_interval   <= itv_ovf;
      rst_req_por    <= wd_ovf & rst_en & ~rst_type;
      rst_req_manual <= wd_ovf & rst_en & rst_type;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
      ADDR_CTL: begin
        bus_rdata[CTL_RUN_BIT]  = run;
        bus_rdata[CTL_MODE_BIT] = wd_mode;
      end
      ADDR_STAT: begin
        bus_rdata[4:0]            = STAT_RSVD;
        bus_rdata[STAT_FLAG_BIT]  = flag;
        bus_rdata[STAT_RSTEN_BIT] = rst_en;
        bus_rdata[STAT_RTYPE_BIT] = rst_type;
      end
      default:   bus_rdata = '0;
    endcase
  end

  // R6: at most one event output is active at a time
  assert_event_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_interval, rst_req_por, rst_req_manual}));

  // R6: reset requests last one cycle
  assert_por_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_por |=> !rst_req_por);
  assert_man_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_manual |=> !rst_req_manual);

  // R5: interval pulse lasts one cycle
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_interval |=> !irq_interval);

  // R5 R11: interval overflow leaves flag and control untouched
  assert_interval_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (itv_ovf && !bus_wr) |=> ($stable(flag) && run && !wd_mode));
endmodule

// File: tb/test_wdog_reset_ctrl.sv
`timescale 1ns/1ps
module test_wdog_reset_ctrl;
  localparam int W = 4;
  localparam logic [1:0] A_CNT = 2'd0, A_CTL = 2'd1, A_STAT = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_interval, rst_req_por, rst_req_manual;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_reset_ctrl #(.CNT_W(W)) i_wdog_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_interval(irq_interval),
    .rst_req_por(rst_req_por), .rst_req_manual(rst_req_manual)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic [2:0] events();
    return {irq_interval, rst_req_por, rst_req_manual};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    do_reset();

    // R1 reset state
    bus_read(A_CNT, rd);  chk("R1 counter reset", rd, 8'h00);
    bus_read(A_CTL, rd);  chk("R1 control reset", rd, 8'h00);
    bus_read(A_STAT, rd); chk("R1 status reset", rd, 8'h1F);
    chk("R1 outputs low", events(), 3'b000);

    // R2 status field layout
    bus_write(A_STAT, 8'h60); bus_read(A_STAT, rd); chk("R2 set bits 6,5", rd, 8'h7F);
    bus_write(A_STAT, 8'h00); bus_read(A_STAT, rd); chk("R2 reserved ignore 0", rd, 8'h1F);
    bus_write(A_STAT, 8'h40); bus_read(A_STAT, rd); chk("R2 reset enable only", rd, 8'h5F);
    bus_write(A_STAT, 8'h20); bus_read(A_STAT, rd); chk("R2 reset type only", rd, 8'h3F);

    // R3 control and counter fields
    bus_write(A_CTL, 8'hFF); bus_read(A_CTL, rd); chk("R3 control unused bits", rd, 8'h03);
    bus_write(A_CTL, 8'h00);
    bus_write(A_CNT, 8'h35); bus_read(A_CNT, rd); chk("R3 counter width", rd, 8'h05);
    repeat (3) do_tick();
    bus_read(A_CNT, rd); chk("R3 hold while stopped", rd, 8'h05);
    bus_write(A_CTL, 8'h01);
    do_tick();
    bus_read(A_CNT, rd); chk("R3 increment", rd, 8'h06);
    @(negedge clk);
    tick = 1'b1; bus_addr = A_CNT; bus_wdata = 8'h09; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    bus_read(A_CNT, rd); chk("R3 write beats tick", rd, 8'h09);

    // R4 R5 R6 R7 R11 sweep: mode x enable x type x preload
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int pi = 0; pi < 3; pi++) begin
        logic wd, en, ty;
        int p, n;
        logic [2:0] exp_ev;
        string tag;
        wd = cfg[2]; en = cfg[1]; ty = cfg[0];
        p = (pi == 0) ? 0 : (pi == 1) ? 7 : 15;
        n = 16 - p;
        tag = !wd ? "R5 R11 interval" : (en ? "R6 reset request" : "R7 self clear");
        exp_ev = !wd ? 3'b100 : (en ? (ty ? 3'b001 : 3'b010) : 3'b000);
        do_reset();
        bus_write(A_STAT, {1'b0, en, ty, 5'b0});
        bus_write(A_CTL, {6'b0, wd, 1'b1});
        bus_write(A_CNT, 8'(p));
        for (int k = 1; k <= n; k++) begin
          do_tick();
          if (k < n) chk({tag, " early quiet"}, events(), 3'b000);
          else       chk({tag, " pulse"}, events(), exp_ev);
          if (k == n - 1) begin
            bus_read(A_CNT, rd);
            chk("R3 count before wrap", rd, 8'h0F);
          end
        end
        @(negedge clk);
        chk({tag, " single cycle"}, events(), 3'b000);
        bus_read(A_STAT, rd);
        chk("R4 flag after overflow", rd, {wd, en, ty, 5'h1F});
        bus_read(A_CTL, rd);
        chk("R7 control after overflow", rd, (wd && !en) ? 8'h00 : {6'b0, wd, 1'b1});
        bus_read(A_CNT, rd);
        chk("R4 counter wrapped", rd, 8'h00);
      end
    end

    // R8 R9 qualified clear
    do_reset();
    bus_write(A_CTL, 8'h03); bus_write(A_CNT, 8'h0F); do_tick();
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, rd); chk("R8 write without read keeps flag", rd, 8'h9F);
    bus_write(A_STAT, 8'hE0);
    bus_read(A_STAT, rd); chk("R8 write one keeps flag", rd, 8'hFF);
    bus_write(A_STAT, 8'h80);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, rd); chk("R9 second write not qualified", rd, 8'h9F);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, rd); chk("R8 qualified clear", rd, 8'h1F);

    // R10 overflow meets clearing write
    bus_write(A_CTL, 8'h03); bus_write(A_CNT, 8'h0F); do_tick();
    bus_read(A_STAT, rd); chk("R10 flag set again", rd, 8'h9F);
    bus_write(A_CTL, 8'h03); bus_write(A_CNT, 8'h0F);
    @(negedge clk);
    tick = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    bus_read(A_STAT, rd); chk("R10 overflow wins over clear", rd, 8'h9F);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, rd); chk("R10 later clear works", rd, 8'h1F);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule